// File: doc/BRIEF.md
# Dual-Slope Compare Output Generator

This block forms the two waveform outputs of an up/down timer used for centre-aligned PWM. A counter outside the block supplies four things: its current value, the direction of the step that produced that value, the present TOP value and a strobe that marks each counter step. Each of the two channels, A and B, compares its buffered compare value against the counter. A two-bit output action code per channel then decides what a match does to that channel's output.

An action code with its upper bit set makes the output follow the count direction. With the lower bit clear, a match while rising drives the output low and a match while falling drives it high. With the lower bit set the polarity is reversed. A compare value at either end of the count range pins the output to a constant level for the whole period, so the output never glitches at the turning point. Code 01 is a toggle, and only channel A has it, and only in the dual-slope waveform modes 8 to 11. Code 00 releases the pin to ordinary port use.

Each output and its pin-override enable is a register. Both change on the clock edge that samples the inputs.

Top module: `dual_slope_cmp_out`

## Requirements
- R1: A channel whose action code is 00 drives its enable low after the next clock edge, and its waveform output keeps its last value.
- R2: With action code 10, a counter step whose value equals the channel's compare value drives the output to 0 when the step was upward (cntUp=1) and to 1 when it was downward (cntUp=0).
- R3: With action code 11, a matching upward step drives the output to 1 and a matching downward step drives it to 0.
- R4: Channel A with action code 01 and waveform mode 8, 9, 10 or 11 (waveMode[3:2]=2'b10) inverts its output on every matching step and holds its enable high.
- R5: Action code 01 on channel B, or on channel A in any waveform mode outside 8 to 11, leaves that channel disconnected: the enable is low and the output does not change.
- R6: When the compare value equals cntTop and the action code's upper bit is set, every counter step drives the output to 1 for code 10 and to 0 for code 11, whatever the counter value.
- R7: When the compare value equals 0 (and differs from cntTop) and the action code's upper bit is set, every counter step drives the output to 0 for code 10 and to 1 for code 11.
- R8: In a cycle where cntStep is low, neither output changes.
- R9: Reset clears both outputs and both enables to 0. Otherwise the outputs take their new value on the clock edge at which cntStep and the matching inputs are sampled.
- R10: An enable follows its channel's action code and the waveform mode one clock edge later, whether or not cntStep is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntStep | input | 1 | High in each cycle in which the counter presents a new value |
| cntUp | input | 1 | Direction of the step that produced cntVal (1 = upward) |
| cntVal | input | CNT_W | Current counter value |
| cntTop | input | CNT_W | Current TOP of the count range |
| cmpA | input | CNT_W | Buffered compare value, channel A |
| cmpB | input | CNT_W | Buffered compare value, channel B |
| waveMode | input | 4 | Active waveform mode number |
| comModeA | input | 2 | Output action code, channel A |
| comModeB | input | 2 | Output action code, channel B |
| waveA | output | 1 | Registered waveform, channel A |
| waveB | output | 1 | Registered waveform, channel B |
| enA | output | 1 | Pin-override enable, channel A |
| enB | output | 1 | Pin-override enable, channel B |

## Verification
Suppose a channel's direction decode or its end-of-range detection is wrong. Then a waveform port has the wrong level on the edge right after the offending counter step, and it keeps that level until the next match or pinned step. For this reason every vector is checked one edge after it is applied. A wrong connect decode shows up at an enable port one edge after the action code changes. A missed or extra toggle on channel A inverts every later level of that channel, so the vector sequence is ordered so that toggles and holds alternate.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  localparam int NUM_CH = 2;

  // comparison results for one channel, produced by the datapath
  typedef struct packed {
    logic hit;    // compare value equals counter value
    logic atTop;  // compare value equals TOP
    logic atBot;  // compare value equals zero
  } chan_flag_t;

  // strobes from control to datapath for one channel
  typedef struct packed {
    logic setOut;
    logic clrOut;
    logic togOut;
    logic connect;
  } chan_stb_t;
endpackage

// File: rtl/dsc_ctrl.sv
module dsc_ctrl
  import dsc_pkg::*;
(
  input  logic                         cntStep,
  input  logic                         cntUp,
  input  logic [3:0]                   waveMode,
  input  logic [NUM_CH-1:0][1:0]       comMode,
  input  chan_flag_t [NUM_CH-1:0]      flags,
  output chan_stb_t  [NUM_CH-1:0]      stb
);
  // toggle exists only in the dual-slope modes numbered 8..11
  logic modeTogOk;
  assign modeTogOk = (waveMode[3:2] == 2'b10);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam bit CAN_TOGGLE = (g == 0);
    logic togOk, fire, level;

    always_comb begin
      togOk = CAN_TOGGLE && modeTogOk;
      fire  = 1'b0;
      level = 1'b0;
      if (comMode[g][1]) begin
        if (flags[g].atTop) begin
          fire  = 1'b1;
          level = ~comMode[g][0];
        end else if (flags[g].atBot) begin
          fire  = 1'b1;
          level = comMode[g][0];
        end else if (flags[g].hit) begin
          fire  = 1'b1;
          level = cntUp ? comMode[g][0] : ~comMode[g][0];
        end
      end
      stb[g].connect = comMode[g][1] | ((comMode[g] == 2'b01) & togOk);
      stb[g].setOut  = cntStep & fire & level;
      stb[g].clrOut  = cntStep & fire & ~level;
      stb[g].togOut  = cntStep & (comMode[g] == 2'b01) & togOk & flags[g].hit;
    end

    // R4 / R5: only one action per step, and only one kind of action per code
    always_comb begin
      p_one_action_r4: assert ($onehot0({stb[g].setOut, stb[g].clrOut, stb[g].togOut}))
        else $error("more than one output action on channel %0d", g);
    end
  end
endmodule

// File: rtl/dsc_datapath.sv
module dsc_datapath
  import dsc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              cntStep,
  input  logic [CNT_W-1:0]                  cntVal,
  input  logic [CNT_W-1:0]                  cntTop,
  input  logic [NUM_CH-1:0][CNT_W-1:0]      cmpVal,
  input  chan_stb_t  [NUM_CH-1:0]           stb,
  output chan_flag_t [NUM_CH-1:0]           flags,
  output logic [NUM_CH-1:0]                 waveQ,
  output logic [NUM_CH-1:0]                 enQ
);
  localparam logic [CNT_W-1:0] BOTTOM = '0;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign flags[g].hit   = (cmpVal[g] == cntVal);
    assign flags[g].atTop = (cmpVal[g] == cntTop);
    assign flags[g].atBot = (cmpVal[g] == BOTTOM);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        waveQ[g] <= 1'b0;
        enQ[g]   <= 1'b0;
      end else begin
        enQ[g] <= stb[g].connect;
        if (stb[g].setOut)      waveQ[g] <= 1'b1;
        else if (stb[g].clrOut) waveQ[g] <= 1'b0;
        else if (stb[g].togOut) waveQ[g] <= ~waveQ[g];
      end
    end

    p_set_lands_r3: assert property (@(posedge clk) disable iff (!rstN)
      stb[g].setOut |=> waveQ[g]);
    p_clr_lands_r2: assert property (@(posedge clk) disable iff (!rstN)
      stb[g].clrOut |=> !waveQ[g]);
    p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
      !cntStep |=> $stable(waveQ[g]));
  end
endmodule

// File: rtl/dual_slope_cmp_out.sv
module dual_slope_cmp_out
  import dsc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntStep,
  input  logic             cntUp,
  input  logic [CNT_W-1:0] cntVal,
  input  logic [CNT_W-1:0] cntTop,
  input  logic [CNT_W-1:0] cmpA,
  input  logic [CNT_W-1:0] cmpB,
  input  logic [3:0]       waveMode,
  input  logic [1:0]       comModeA,
  input  logic [1:0]       comModeB,
  output logic             waveA,
  output logic             waveB,
  output logic             enA,
  output logic             enB
);
  chan_flag_t [NUM_CH-1:0]          flags;
  chan_stb_t  [NUM_CH-1:0]          stb;
  logic [NUM_CH-1:0][CNT_W-1:0]     cmpVal;
  logic [NUM_CH-1:0][1:0]           comMode;
  logic [NUM_CH-1:0]                waveQ, enQ;

  assign cmpVal  = {cmpB, cmpA};
  assign comMode = {comModeB, comModeA};

  dsc_ctrl u_ctrl (
    .cntStep (cntStep),
    .cntUp   (cntUp),
    .waveMode(waveMode),
    .comMode (comMode),
    .flags   (flags),
    .stb     (stb)
  );

  dsc_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .cntStep(cntStep),
    .cntVal (cntVal),
    .cntTop (cntTop),
    .cmpVal (cmpVal),
    .stb    (stb),
    .flags  (flags),
    .waveQ  (waveQ),
    .enQ    (enQ)
  );

  assign waveA = waveQ[0];
  assign waveB = waveQ[1];
  assign enA   = enQ[0];
  assign enB   = enQ[1];

  p_disc_a_r1: assert property (@(posedge clk) disable iff (!rstN)
    (comModeA == 2'b00) |=> !enA);
  p_disc_b_r1: assert property (@(posedge clk) disable iff (!rstN)
    (comModeB == 2'b00) |=> !enB);
  p_b_no_toggle_r5: assert property (@(posedge clk) disable iff (!rstN)
    (comModeB == 2'b01) |=> (!enB && $stable(waveB)));
  p_toggle_a_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cntStep && comModeA == 2'b01 && waveMode[3:2] == 2'b10 && cmpA == cntVal)
      |=> (waveA != $past(waveA)));
  p_top_high_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cntStep && comModeA == 2'b10 && cmpA == cntTop) |=> waveA);
  p_bot_high_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cntStep && comModeA == 2'b11 && cmpA == '0 && cntTop != '0) |=> waveA);
endmodule

// File: tb/dual_slope_cmp_out_bench.sv
module dual_slope_cmp_out_bench;
  localparam int CNT_W = 16;
  localparam int NV    = 15;
  localparam logic [CNT_W-1:0] TOPV = 16'd100;

  typedef struct packed {
    logic [3:0]       mode;
    logic [1:0]       comA;
    logic [1:0]       comB;
    logic [CNT_W-1:0] cA;
    logic [CNT_W-1:0] cB;
    logic [CNT_W-1:0] cnt;
    logic             up;
    logic             step;
    logic             xA;
    logic             xB;
    logic             xEnA;
    logic             xEnB;
    logic [3:0]       req;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{4'd10, 2'b10, 2'b11, 16'd40, 16'd60, 16'd39, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd10}, // R10 enables rise, no match
    '{4'd10, 2'b10, 2'b11, 16'd40, 16'd60, 16'd40, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd2},  // R2 A up match clears
    '{4'd10, 2'b10, 2'b11, 16'd40, 16'd60, 16'd60, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'd3},  // R3 B up match sets
    '{4'd10, 2'b10, 2'b11, 16'd40, 16'd60, 16'd60, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd3},  // R3 B down match clears
    '{4'd10, 2'b10, 2'b11, 16'd40, 16'd60, 16'd40, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'd2},  // R2 A down match sets
    '{4'd10, 2'b11, 2'b11, 16'd40, 16'd60, 16'd40, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd8},  // R8 no step, hold
    '{4'd10, 2'b11, 2'b11, 16'd40, 16'd60, 16'd40, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd3},  // R3 A down match clears
    '{4'd10, 2'b01, 2'b01, 16'd40, 16'd60, 16'd40, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'd4},  // R4 toggle up; B off
    '{4'd10, 2'b01, 2'b01, 16'd40, 16'd60, 16'd41, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'd4},  // R4 no match no toggle
    '{4'd10, 2'b01, 2'b01, 16'd40, 16'd60, 16'd41, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'd5},  // R5 B code 01 stays off
    '{4'd1,  2'b01, 2'b01, 16'd40, 16'd60, 16'd40, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 A code 01 mode 1 off
    '{4'd10, 2'b11, 2'b10, 16'd100, 16'd100, 16'd50, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'd6}, // R6 cmp at TOP pins
    '{4'd10, 2'b11, 2'b10, 16'd0,  16'd0,  16'd50, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'd7}, // R7 cmp at 0 pins
    '{4'd10, 2'b00, 2'b00, 16'd0,  16'd0,  16'd40, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd1}, // R1 disconnected hold
    '{4'd10, 2'b10, 2'b10, 16'd0,  16'd100, 16'd100, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'd6} // R6 TOP step, R7 zero
  };

  logic             clk = 1'b0;
  logic             rstN;
  logic             cntStep, cntUp;
  logic [CNT_W-1:0] cntVal, cntTop, cmpA, cmpB;
  logic [3:0]       waveMode;
  logic [1:0]       comModeA, comModeB;
  logic             waveA, waveB, enA, enB;
  int               checks = 0;
  int               errors = 0;
  bit               done = 1'b0;

  always #4 clk = ~clk;

  dual_slope_cmp_out #(.CNT_W(CNT_W)) u_dual_slope_cmp_out (
    .clk(clk), .rstN(rstN), .cntStep(cntStep), .cntUp(cntUp),
    .cntVal(cntVal), .cntTop(cntTop), .cmpA(cmpA), .cmpB(cmpB),
    .waveMode(waveMode), .comModeA(comModeA), .comModeB(comModeB),
    .waveA(waveA), .waveB(waveB), .enA(enA), .enB(enB)
  );

  task automatic check(input string what, input int req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input int req, input logic a, input logic b, input logic ea, input logic eb);
    check("waveA", req, waveA, a);
    check("waveB", req, waveB, b);
    check("enA",   req, enA,   ea);
    check("enB",   req, enB,   eb);
  endtask

  initial begin
    rstN = 1'b0; cntStep = 1'b0; cntUp = 1'b1; cntVal = '0; cntTop = TOPV;
    cmpA = '0; cmpB = '0; waveMode = 4'd10; comModeA = 2'b10; comModeB = 2'b11;
    repeat (3) @(posedge clk);
    #1;
    checkAll(9, 1'b0, 1'b0, 1'b0, 1'b0); // R9 reset state
    @(negedge clk);
    rstN = 1'b1;
    comModeA = 2'b00; comModeB = 2'b00;
    @(posedge clk); #1;
    checkAll(1, 1'b0, 1'b0, 1'b0, 1'b0); // R1 disconnected after reset

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      waveMode = VECS[i].mode; comModeA = VECS[i].comA; comModeB = VECS[i].comB;
      cmpA = VECS[i].cA; cmpB = VECS[i].cB; cntVal = VECS[i].cnt;
      cntUp = VECS[i].up; cntStep = VECS[i].step;
      @(posedge clk); #1;
      checkAll(int'(VECS[i].req), VECS[i].xA, VECS[i].xB, VECS[i].xEnA, VECS[i].xEnB);
    end

    // R10: enable follows a code change without any counter step
    @(negedge clk);
    cntStep = 1'b0; comModeA = 2'b11; comModeB = 2'b00;
    @(posedge clk); #1;
    check("enA no step", 10, enA, 1'b1);
    check("enB no step", 10, enB, 1'b0);
    check("waveB held", 8, waveB, 1'b1);

    // R9: reset in mid-run clears everything
    @(negedge clk);
    rstN = 1'b0;
    @(posedge clk); #1;
    checkAll(9, 1'b0, 1'b0, 1'b0, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule